// File: doc/BRIEF.md
# Key-Protected Countdown Watchdog

This block is an independent watchdog that runs from a slow low-speed oscillator of about 40 kHz. It counts down from a 12-bit reload value through a selectable power-of-two prescaler. When the count is used up it raises a one-cycle reset request, reloads, and carries on counting. The slow oscillator reaches the block as a one-cycle enable strobe, `lsi_tick`, in the block's own clock domain. The counter only advances on cycles where that strobe is high.

Software drives the block through four small registers. The command register accepts only three 16-bit magic keys. One key starts the timer, one feeds it (reloads the count and locks the configuration), and one unlocks the configuration. The prescaler and reload registers take writes only while they are unlocked. A new value in either register is held as pending until the next slow tick copies it into the counting logic. A status register shows a pending flag for each. A debug-hold input freezes the countdown while the processor is halted.

Top module: `key_watchdog`

## Requirements
- R1: After reset the prescaler register reads 0, the reload register reads 0xFFF, the status register reads 0, the configuration is locked, the timer is stopped and `wdg_rst_req` is low.
- R2: Writing 0xCCCC to the command register (address 0) starts the timer and loads the count. Nothing except reset stops it afterwards. While stopped, no reset request is ever raised.
- R3: Writing 0xAAAA to the command register reloads the count and restarts the prescaler. It also locks the prescaler and reload registers again.
- R4: Writing 0x5555 to the command register unlocks the prescaler (address 1, bits 2:0) and reload (address 2, bits 11:0) registers. While they are locked, writes to them leave their contents unchanged. Any other command value has no effect.
- R5: Prescaler codes 0 to 6 select divide-by 4, 8, 16, 32, 64, 128 and 256. Code 7 also selects divide-by-256.
- R6: After a start or feed, the reset request is raised on the (reload+1)×divider-th slow tick. It is visible in the clock cycle after that tick and lasts exactly one cycle. The count then reloads, so the next request follows another full period.
- R7: Status bit 0 (prescaler) and bit 1 (reload) go to 1 when an accepted write is made to that register. Each clears on the first slow tick in a later cycle. A write and a tick in the same cycle leave the bit set.
- R8: While `dbg_halt` is high the countdown and the prescaler hold their state. Counting resumes where it stopped once `dbg_halt` falls.
- R9: A feed that arrives in the same cycle as the expiring tick takes priority. No reset request is raised, and a full new period begins.
- R10: The count does not change in cycles without a slow tick, however many clock cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lsi_tick | input | 1 | One-cycle strobe at the slow oscillator rate |
| dbg_halt | input | 1 | High while the core is halted by a debugger |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 command, 1 prescaler, 2 reload, 3 status |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 16 | Read data (command reads 0) |
| wdg_rst_req | output | 1 | One-cycle reset request |

## Verification
A feed key write and the tick that would expire the count can fall in the same cycle. The bench provokes this by driving the 0xAAAA write together with the final tick of a period. It judges the outcome by the absence of a reset request in the following cycle, and by a request arriving exactly one full period later. A second collision is a configuration write landing together with a slow tick. The bench judges it by the pending flag staying set until the next tick.

// File: rtl/wdt_pkg.sv
// Shared constants for the key-protected watchdog: command keys and the
// register address map. Assumes a 16-bit command path.
package wdt_pkg;
    localparam logic [15:0] KEY_START  = 16'hCCCC;
    localparam logic [15:0] KEY_FEED   = 16'hAAAA;
    localparam logic [15:0] KEY_UNLOCK = 16'h5555;

    typedef enum logic [1:0] {
        ADDR_CMD  = 2'd0,
        ADDR_PSC  = 2'd1,
        ADDR_RLD  = 2'd2,
        ADDR_STAT = 2'd3
    } wdt_addr_e;
endpackage

// File: rtl/wdt_regs.sv
// Register file of the watchdog: decodes command keys, keeps the lock,
// holds the software-visible prescaler and reload values and copies them
// into the counting logic on the next slow tick, with a pending flag each.
// Assumes DATA_W is at least 16 and wider than PSC_W and RLD_W.
module wdt_regs #(
    parameter int DATA_W = 16,
    parameter int PSC_W  = 3,
    parameter int RLD_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsi_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              start_cmd,
    output logic              feed_cmd,
    output logic              unlocked,
    output logic [PSC_W-1:0]  psc_val,
    output logic [RLD_W-1:0]  rld_val,
    output logic              psc_busy,
    output logic              rld_busy,
    output logic [PSC_W-1:0]  act_psc,
    output logic [RLD_W-1:0]  act_rld
);
    import wdt_pkg::*;

    logic cmd_wr, unlock_cmd, psc_wr, rld_wr;

    // Key decode and gated register write strobes.
    always_comb begin
        cmd_wr     = wr_en && (wr_addr == ADDR_CMD);
        start_cmd  = cmd_wr && (wr_data[15:0] == KEY_START);
        feed_cmd   = cmd_wr && (wr_data[15:0] == KEY_FEED);
        unlock_cmd = cmd_wr && (wr_data[15:0] == KEY_UNLOCK);
        psc_wr     = wr_en && (wr_addr == ADDR_PSC) && unlocked;
        rld_wr     = wr_en && (wr_addr == ADDR_RLD) && unlocked;
    end

    // Write-protection state: unlock key opens, feed key closes.
    always_ff @(posedge clk) begin
        if (!rst_n)          unlocked <= 1'b0;
        else if (unlock_cmd) unlocked <= 1'b1;
        else if (feed_cmd)   unlocked <= 1'b0;
    end

    // Software-visible prescaler value and its pending flag and active copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_val  <= '0;
            psc_busy <= 1'b0;
            act_psc  <= '0;
        end else begin
            if (psc_wr) begin
                psc_val  <= wr_data[PSC_W-1:0];
                psc_busy <= 1'b1;
            end else if (lsi_tick) begin
                psc_busy <= 1'b0;
            end
            if (psc_busy && lsi_tick && !psc_wr) act_psc <= psc_val;
        end
    end

    // Software-visible reload value and its pending flag and active copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_val  <= '1;
            rld_busy <= 1'b0;
            act_rld  <= '1;
        end else begin
            if (rld_wr) begin
                rld_val  <= wr_data[RLD_W-1:0];
                rld_busy <= 1'b1;
            end else if (lsi_tick) begin
                rld_busy <= 1'b0;
            end
            if (rld_busy && lsi_tick && !rld_wr) act_rld <= rld_val;
        end
    end
endmodule

// File: rtl/wdt_prescale.sv
// Prescaler of the watchdog: counts enabled slow ticks and flags the last
// tick of each divide period. The divider is 2^(code+MIN_SHIFT), saturating
// at 2^MAX_SHIFT. Assumes clr takes priority over en.
module wdt_prescale #(
    parameter int PSC_W     = 3,
    parameter int MIN_SHIFT = 2,
    parameter int MAX_SHIFT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [PSC_W-1:0] code,
    output logic             term
);
    localparam int PRE_W = MAX_SHIFT;
    localparam int SH_W  = $clog2(MAX_SHIFT + (1 << PSC_W) + 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit;
    logic [SH_W-1:0]  shift;

    // Divider exponent with saturation, and the matching terminal count.
    always_comb begin
        shift = SH_W'(code) + SH_W'(MIN_SHIFT);
        if (shift > SH_W'(MAX_SHIFT)) shift = SH_W'(MAX_SHIFT);
        limit = {PRE_W{1'b1}} >> (SH_W'(MAX_SHIFT) - shift);
        term  = en && !clr && (pre_cnt >= limit);
    end

    // Tick counter, restarted by clr and wrapped at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)         pre_cnt <= '0;
        else if (en && pre_cnt >= limit) pre_cnt <= '0;
        else if (en)               pre_cnt <= pre_cnt + 1'b1;
    end
endmodule

// File: rtl/wdt_down.sv
// Main down-counter of the watchdog: loads the reload value, steps on each
// prescaler terminal, and on stepping past zero issues a one-cycle request
// and reloads. Assumes load takes priority over step.
module wdt_down #(
    parameter int RLD_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [RLD_W-1:0] rld,
    output logic [RLD_W-1:0] cnt,
    output logic             req
);
    // Countdown with reload and registered request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '1;
            req <= 1'b0;
        end else begin
            req <= 1'b0;
            if (load) begin
                cnt <= rld;
            end else if (step) begin
                if (cnt == '0) begin
                    req <= 1'b1;
                    cnt <= rld;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/key_watchdog.sv
// Top of the key-protected watchdog: registers, run state, prescaler and
// down-counter. Assumes lsi_tick is already synchronous to clk and one
// cycle wide.
module key_watchdog #(
    parameter int DATA_W    = 16,
    parameter int PSC_W     = 3,
    parameter int RLD_W     = 12,
    parameter int MIN_SHIFT = 2,
    parameter int MAX_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsi_tick,
    input  logic              dbg_halt,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wdg_rst_req
);
    import wdt_pkg::*;

    logic             start_cmd, feed_cmd, unlocked;
    logic [PSC_W-1:0] psc_val, act_psc;
    logic [RLD_W-1:0] rld_val, act_rld, cnt_val;
    logic             psc_busy, rld_busy;
    logic             running, cnt_en, restart, pre_term;

    wdt_regs #(.DATA_W(DATA_W), .PSC_W(PSC_W), .RLD_W(RLD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .lsi_tick(lsi_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start_cmd(start_cmd), .feed_cmd(feed_cmd), .unlocked(unlocked),
        .psc_val(psc_val), .rld_val(rld_val),
        .psc_busy(psc_busy), .rld_busy(rld_busy),
        .act_psc(act_psc), .act_rld(act_rld)
    );

    // Run state: set by the start key, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         running <= 1'b0;
        else if (start_cmd) running <= 1'b1;
    end

    // Count enable and restart conditions.
    always_comb begin
        cnt_en  = running && lsi_tick && !dbg_halt;
        restart = start_cmd || feed_cmd;
    end

    wdt_prescale #(.PSC_W(PSC_W), .MIN_SHIFT(MIN_SHIFT), .MAX_SHIFT(MAX_SHIFT)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(restart), .en(cnt_en),
        .code(act_psc), .term(pre_term)
    );

    wdt_down #(.RLD_W(RLD_W)) u_down (
        .clk(clk), .rst_n(rst_n), .load(restart), .step(pre_term),
        .rld(act_rld), .cnt(cnt_val), .req(wdg_rst_req)
    );

    // Read multiplexer over the register map.
    always_comb begin
        case (rd_addr)
            ADDR_PSC:  rd_data = {{(DATA_W-PSC_W){1'b0}}, psc_val};
            ADDR_RLD:  rd_data = {{(DATA_W-RLD_W){1'b0}}, rld_val};
            ADDR_STAT: rd_data = {{(DATA_W-2){1'b0}}, rld_busy, psc_busy};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/wdt_sva.sv
// Checker for the key-protected watchdog, bound to the top module.
module wdt_sva #(
    parameter int DATA_W = 16,
    parameter int PSC_W  = 3,
    parameter int RLD_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lsi_tick,
    input logic              dbg_halt,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              running,
    input logic              unlocked,
    input logic [PSC_W-1:0]  psc_val,
    input logic              psc_busy,
    input logic [RLD_W-1:0]  cnt_val,
    input logic              wdg_rst_req
);
    a_r2_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !wdg_rst_req);

    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst_req |=> !wdg_rst_req);

    a_r3_feed_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && wr_data[15:0] == 16'hAAAA) |=> !unlocked);

    a_r4_locked_psc: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && !unlocked) |=> $stable(psc_val));

    a_r7_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && unlocked) |=> psc_busy);

    a_r7_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_busy && lsi_tick && !(wr_en && wr_addr == 2'd1 && unlocked)) |=> !psc_busy);

    a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && !(wr_en && wr_addr == 2'd0)) |=> $stable(cnt_val));

    a_r10_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!lsi_tick && !(wr_en && wr_addr == 2'd0)) |=> $stable(cnt_val));
endmodule

bind key_watchdog wdt_sva #(.DATA_W(DATA_W), .PSC_W(PSC_W), .RLD_W(RLD_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .lsi_tick(lsi_tick), .dbg_halt(dbg_halt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .running(running), .unlocked(unlocked), .psc_val(psc_val),
    .psc_busy(psc_busy), .cnt_val(cnt_val), .wdg_rst_req(wdg_rst_req)
);

// File: tb/key_watchdog_tb.sv
module key_watchdog_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lsi_tick = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        wdg_rst_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    key_watchdog u_dut (
        .clk(clk), .rst_n(rst_n), .lsi_tick(lsi_tick), .dbg_halt(dbg_halt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .wdg_rst_req(wdg_rst_req)
    );

    localparam int VEC_N = 7;
    localparam logic [2:0]  V_PSC [VEC_N] = '{3'd0, 3'd0, 3'd1, 3'd2, 3'd5, 3'd6, 3'd7};
    localparam logic [11:0] V_RLD [VEC_N] = '{12'd0, 12'd3, 12'd2, 12'd1, 12'd0, 12'd0, 12'd1};
    localparam int          V_PER [VEC_N] = '{4, 16, 24, 32, 128, 256, 512};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    // Issue n slow ticks (one cycle high, one low); record first and second pulse index.
    task automatic run_ticks(input int n, input bit feed_last, output int first, output int second);
        first = 0; second = 0;
        for (int i = 1; i <= n; i++) begin
            lsi_tick = 1'b1;
            if (feed_last && i == n) begin
                wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'hAAAA;
            end
            @(negedge clk);
            lsi_tick = 1'b0; wr_en = 1'b0;
            if (wdg_rst_req) begin
                if (first == 0) first = i;
                else if (second == 0) second = i;
            end
            @(negedge clk);
            if (wdg_rst_req) chk("R6 pulse width", 1, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, f, s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(2'd1, v); chk("R1 prescaler", v, 0);
        bus_rd(2'd2, v); chk("R1 reload", v, 12'hFFF);
        bus_rd(2'd3, v); chk("R1 status", v, 0);
        chk("R1 request", int'(wdg_rst_req), 0);

        // R4 locked writes and bad keys ignored
        bus_wr(2'd1, 16'd5);
        bus_rd(2'd1, v); chk("R4 locked write", v, 0);
        bus_rd(2'd3, v); chk("R4 locked status", v, 0);
        bus_wr(2'd0, 16'h1234);
        bus_wr(2'd2, 16'd9);
        bus_rd(2'd2, v); chk("R4 bad key", v, 12'hFFF);

        // R7 pending flag after an unlocked write, cleared by a tick
        bus_wr(2'd0, 16'h5555);
        bus_wr(2'd1, 16'd3);
        bus_rd(2'd1, v); chk("R4 unlocked write", v, 3);
        bus_rd(2'd3, v); chk("R7 pending set", v, 1);
        run_ticks(1, 1'b0, f, s);
        bus_rd(2'd3, v); chk("R7 pending clear", v, 0);

        // R3 feed relocks
        bus_wr(2'd0, 16'hAAAA);
        bus_wr(2'd1, 16'd1);
        bus_rd(2'd1, v); chk("R3 relock", v, 3);

        // R2 stopped timer raises nothing
        bus_wr(2'd0, 16'h5555);
        bus_wr(2'd1, 16'd0);
        bus_wr(2'd2, 16'd0);
        run_ticks(40, 1'b0, f, s);
        chk("R2 stopped", f, 0);
        bus_wr(2'd0, 16'hCCCC);

        // R5/R6 vector table walk
        for (int k = 0; k < VEC_N; k++) begin
            bus_wr(2'd0, 16'h5555);
            bus_wr(2'd1, {13'd0, V_PSC[k]});
            bus_wr(2'd2, {4'd0, V_RLD[k]});
            run_ticks(1, 1'b0, f, s);
            bus_wr(2'd0, 16'hAAAA);
            run_ticks(2 * V_PER[k], 1'b0, f, s);
            chk("R5 R6 first period", f, V_PER[k]);
            chk("R6 second period", s, 2 * V_PER[k]);
        end

        // Configure period 16 (code 0, reload 3)
        bus_wr(2'd0, 16'h5555);
        bus_wr(2'd1, 16'd0);
        bus_wr(2'd2, 16'd3);
        run_ticks(1, 1'b0, f, s);
        bus_wr(2'd0, 16'hAAAA);

        // R8 debug hold freezes the count
        run_ticks(8, 1'b0, f, s);
        chk("R8 before hold", f, 0);
        dbg_halt = 1'b1;
        run_ticks(100, 1'b0, f, s);
        chk("R8 during hold", f, 0);
        dbg_halt = 1'b0;
        run_ticks(8, 1'b0, f, s);
        chk("R8 resume", f, 8);

        // R10 no progress without ticks
        bus_wr(2'd0, 16'hAAAA);
        repeat (300) @(negedge clk);
        chk("R10 idle", int'(wdg_rst_req), 0);
        run_ticks(16, 1'b0, f, s);
        chk("R10 period", f, 16);

        // R2 bogus command does not stop the timer
        bus_wr(2'd0, 16'h0000);
        run_ticks(16, 1'b0, f, s);
        chk("R2 keeps running", f, 16);

        // R9 feed on the expiring tick wins
        bus_wr(2'd0, 16'hAAAA);
        run_ticks(16, 1'b1, f, s);
        chk("R9 no request", f, 0);
        run_ticks(16, 1'b0, f, s);
        chk("R9 next period", f, 16);

        // R7 write and tick together keep the flag set
        bus_wr(2'd0, 16'h5555);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'd5; lsi_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; lsi_tick = 1'b0;
        @(negedge clk);
        bus_rd(2'd3, v); chk("R7 collide set", v, 2);
        run_ticks(1, 1'b0, f, s);
        bus_rd(2'd3, v); chk("R7 collide clear", v, 0);
        bus_wr(2'd0, 16'hAAAA);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule